// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block is the processor-facing half of an SMBus host controller. Software programs a small byte-wide register file with a target address, a command code and data bytes, then writes a control word that carries a start flag and a protocol code. The block then walks the chosen protocol as a series of byte-level operations on a link interface: start, address, command, data, repeated start and stop. A separate bit-level engine, not part of this block, carries out each operation and answers with a one-cycle done pulse.

Status is reported in one register. It holds host busy, transaction complete, device error, byte done and a software ownership semaphore. The semaphore is set by the act of reading it while clear. Block transfers move one byte at a time through a single block data register, with a byte-done handshake that software clears after each byte. A kill request tears down any transfer in progress.

Top module: `smbus_host_seq`

## Requirements
- R1: After reset every status bit reads 0 and the control register reads 0. The registers sit at these offsets: status 0, control 2, command 3, address 4, data0 5, data1 6, block data 7. The command, address and data registers read back what was written.
- R2: In the status register, bit 6 is an ownership semaphore. A status read that returns it as 0 sets it, so every later read returns 1. Writing 1 to bit 6 clears it.
- R3: A control write with bit 6 set starts a transaction with protocol bits 4:2. Status bit 0 (busy) reads 1 until the transaction ends. Control writes are ignored while busy, except for the kill bit. A start with a protocol code other than 001, 010, 011 or 101 is ignored. Control bits 6 and 1 read back as 0.
- R4: On the link, the op codes are 0 start, 1 write, 2 read and 3 stop. Protocol 001 with address bit 0 clear sends start, the address, the command register and stop. With address bit 0 set it sends start, the address, then one read marked last, whose byte goes to data0, then stop.
- R5: Protocol 010 writes start, address, command, data0, stop. As a read it sends start, the address with bit 0 cleared, the command, a repeated start, the address with bit 0 set, one read marked last into data0, then stop.
- R6: Protocol 011 moves the low byte first on the link. Data1 holds the low byte and data0 the high byte, for both writes and reads. In a read, only the second read is marked last.
- R7: A block write (101) sends address and command, then the count from data0, then each payload byte from block data. After each payload byte it sets status bit 7 and waits for software to clear it before it sends the next byte or the stop. A count of 0 goes straight to stop.
- R8: A block read (101, address bit 0 set) uses the repeated-start form of R5. The first read is the count, which goes to data0. Each later read goes to block data. Status bit 7 is set after every read, and the block waits for it to clear. Only the final payload read is marked last.
- R9: Status bit 1 (complete) is set only when the link finishes the stop of an error-free transaction. Writing 1 clears it.
- R10: If the link reports no acknowledge on any written byte, the block skips to stop. It then sets status bit 2, clears busy and leaves bit 1 clear.
- R11: A control write with bit 1 set aborts the transfer in progress and returns to idle at once, with no stop and no completion.
- R12: The irq output equals control bit 0 ANDed with (status bit 1 OR status bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the semaphore) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Completion / error interrupt |
| lk_req | output | 1 | Link operation request |
| lk_op | output | 2 | Link op: 0 start, 1 write, 2 read, 3 stop |
| lk_wdata | output | 8 | Byte to write |
| lk_last | output | 1 | Read is the final one (not acknowledged) |
| lk_done | input | 1 | Link operation finished (one cycle) |
| lk_rdata | input | 8 | Byte read, valid with lk_done |
| lk_nack | input | 1 | Target did not acknowledge, valid with lk_done on a write |

## Verification
Every protocol runs in both directions against a link model. The model records each op, byte and last flag, and the bench compares that log against a sequence it builds from the requirements. This separates the repeated-start read form from the plain write form, and the low-byte-first word order from its reverse. Block transfers are swept over counts 0 to 4, which separates off-by-one counting, a missing wait on the last byte and the zero-count shortcut. No-acknowledge on the address and on a late data byte, kill during a block wait, a restart attempt while busy, and unused protocol codes each check the difference between aborting, ignoring and completing.

// File: rtl/smbus_host_seq.sv
module smbus_host_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       lk_req,
  output logic [1:0] lk_op,
  output logic [7:0] lk_wdata,
  output logic       lk_last,
  input  logic       lk_done,
  input  logic [7:0] lk_rdata,
  input  logic       lk_nack
);

  localparam logic [2:0] P_BYTE  = 3'b001;
  localparam logic [2:0] P_BDATA = 3'b010;
  localparam logic [2:0] P_WORD  = 3'b011;
  localparam logic [2:0] P_BLOCK = 3'b101;
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_RSTART, S_RADDR,
    S_WDAT, S_RDAT, S_BWAIT, S_STOP
  } state_t;

  state_t     state;
  logic [7:0] r_cmd, r_addr, r_d0, r_d1, r_blk;
  logic [2:0] r_proto, cur_proto;
  logic       r_ien, cur_rd, err_flag;
  logic [6:0] cur_adr;
  logic [7:0] idx, blen;
  logic       st_cmp, st_err, st_inuse, st_bd;

  logic busy, xfer, wr_ctl, wr_stat, kill, proto_ok, start_ok;

  assign busy     = (state != S_IDLE);
  assign xfer     = lk_req & lk_done;
  assign wr_ctl   = reg_wr && reg_addr == 3'd2;
  assign wr_stat  = reg_wr && reg_addr == 3'd0;
  assign kill     = wr_ctl && reg_wdata[1];
  assign proto_ok = reg_wdata[4:2] inside {P_BYTE, P_BDATA, P_WORD, P_BLOCK};
  assign start_ok = wr_ctl && reg_wdata[6] && !kill && !busy && proto_ok;
  assign irq      = r_ien & (st_cmp | st_err);

  assign lk_req = state inside {S_START, S_ADDR, S_CMD, S_RSTART, S_RADDR,
                                S_WDAT, S_RDAT, S_STOP};

  always_comb begin
    case (state)
      S_START, S_RSTART: lk_op = OP_START;
      S_RDAT:            lk_op = OP_READ;
      S_STOP:            lk_op = OP_STOP;
      default:           lk_op = OP_WRITE;
    endcase
  end

  always_comb begin
    lk_wdata = 8'h00;
    case (state)
      S_ADDR:  lk_wdata = {cur_adr, (cur_proto == P_BYTE) & cur_rd};
      S_RADDR: lk_wdata = {cur_adr, 1'b1};
      S_CMD:   lk_wdata = r_cmd;
      S_WDAT: begin
        if (cur_proto == P_WORD)       lk_wdata = (idx == 8'd0) ? r_d1 : r_d0;
        else if (cur_proto == P_BLOCK) lk_wdata = (idx == 8'd0) ? r_d0 : r_blk;
        else                           lk_wdata = r_d0;
      end
      default: lk_wdata = 8'h00;
    endcase
  end

  always_comb begin
    lk_last = 1'b0;
    if (state == S_RDAT) begin
      case (cur_proto)
        P_WORD:  lk_last = (idx == 8'd1);
        P_BLOCK: lk_last = (idx != 8'd0) && (idx == blen);
        default: lk_last = 1'b1;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {st_bd, st_inuse, 3'b000, st_err, st_cmp, busy};
      3'd2:    reg_rdata = {3'b000, r_proto, 1'b0, r_ien};
      3'd3:    reg_rdata = r_cmd;
      3'd4:    reg_rdata = r_addr;
      3'd5:    reg_rdata = r_d0;
      3'd6:    reg_rdata = r_d1;
      3'd7:    reg_rdata = r_blk;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      r_cmd <= '0; r_addr <= '0; r_d0 <= '0; r_d1 <= '0; r_blk <= '0;
      r_proto <= '0; r_ien <= 1'b0;
      cur_proto <= '0; cur_rd <= 1'b0; cur_adr <= '0; err_flag <= 1'b0;
      idx <= '0; blen <= '0;
      st_cmp <= 1'b0; st_err <= 1'b0; st_inuse <= 1'b0; st_bd <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd3: r_cmd  <= reg_wdata;
          3'd4: r_addr <= reg_wdata;
          3'd5: r_d0   <= reg_wdata;
          3'd6: r_d1   <= reg_wdata;
          3'd7: r_blk  <= reg_wdata;
          default: ;
        endcase
      end
      if (wr_ctl && !busy) begin
        r_proto <= reg_wdata[4:2];
        r_ien   <= reg_wdata[0];
      end
      if (wr_stat) begin
        if (reg_wdata[1]) st_cmp   <= 1'b0;
        if (reg_wdata[2]) st_err   <= 1'b0;
        if (reg_wdata[6]) st_inuse <= 1'b0;
        if (reg_wdata[7]) st_bd    <= 1'b0;
      end
      if (reg_rd && reg_addr == 3'd0 && !st_inuse) st_inuse <= 1'b1;

      if (kill) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (start_ok) begin
            state     <= S_START;
            cur_proto <= reg_wdata[4:2];
            cur_rd    <= r_addr[0];
            cur_adr   <= r_addr[7:1];
            idx       <= '0;
            blen      <= '0;
            err_flag  <= 1'b0;
          end
          S_START: if (xfer) state <= S_ADDR;
          S_ADDR: if (xfer) begin
            if (lk_nack) begin
              err_flag <= 1'b1;
              state    <= S_STOP;
            end else if (cur_proto == P_BYTE && cur_rd) state <= S_RDAT;
            else state <= S_CMD;
          end
          S_CMD: if (xfer) begin
            if (lk_nack) begin
              err_flag <= 1'b1;
              state    <= S_STOP;
            end else if (cur_proto == P_BYTE) state <= S_STOP;
            else if (cur_rd) state <= S_RSTART;
            else state <= S_WDAT;
          end
          S_RSTART: if (xfer) state <= S_RADDR;
          S_RADDR: if (xfer) begin
            if (lk_nack) begin
              err_flag <= 1'b1;
              state    <= S_STOP;
            end else state <= S_RDAT;
          end
          S_WDAT: if (xfer) begin
            if (lk_nack) begin
              err_flag <= 1'b1;
              state    <= S_STOP;
            end else if (cur_proto == P_WORD) begin
              if (idx == 8'd0) idx <= 8'd1;
              else state <= S_STOP;
            end else if (cur_proto == P_BLOCK) begin
              if (idx == 8'd0) begin
                blen <= r_d0;
                if (r_d0 == 8'd0) state <= S_STOP;
                else idx <= 8'd1;
              end else begin
                st_bd <= 1'b1;
                state <= S_BWAIT;
              end
            end else state <= S_STOP;
          end
          S_RDAT: if (xfer) begin
            if (cur_proto == P_WORD) begin
              if (idx == 8'd0) begin
                r_d1 <= lk_rdata;
                idx  <= 8'd1;
              end else begin
                r_d0  <= lk_rdata;
                state <= S_STOP;
              end
            end else if (cur_proto == P_BLOCK) begin
              if (idx == 8'd0) begin
                r_d0 <= lk_rdata;
                blen <= lk_rdata;
              end else r_blk <= lk_rdata;
              st_bd <= 1'b1;
              state <= S_BWAIT;
            end else begin
              r_d0  <= lk_rdata;
              state <= S_STOP;
            end
          end
          S_BWAIT: if (!st_bd) begin
            if (idx == blen) state <= S_STOP;
            else begin
              idx   <= idx + 8'd1;
              state <= cur_rd ? S_RDAT : S_WDAT;
            end
          end
          S_STOP: if (xfer) begin
            state <= S_IDLE;
            if (err_flag) st_err <= 1'b1;
            else          st_cmp <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_INUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == 3'd0) |=> st_inuse); // R2
  AST_BUSY_HOLDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctl && !reg_wdata[1]) |=> ($stable(cur_proto) && $stable(r_proto))); // R3
  AST_BD_FROM_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_bd) |-> $past(lk_done)); // R7
  AST_CMP_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_cmp) |-> $past(lk_req && lk_op == OP_STOP && lk_done)); // R9
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err) |-> (!busy && $past(lk_op == OP_STOP))); // R10
  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && !lk_req)); // R11

endmodule

// File: tb/smbus_host_seq_tb.sv
module smbus_host_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, lk_req, lk_last;
  logic [1:0] lk_op;
  logic [7:0] lk_wdata;
  logic lk_done, lk_nack;
  logic [7:0] lk_rdata;

  always #2 clk = ~clk;

  smbus_host_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .lk_req(lk_req),
    .lk_op(lk_op), .lk_wdata(lk_wdata), .lk_last(lk_last), .lk_done(lk_done),
    .lk_rdata(lk_rdata), .lk_nack(lk_nack));

  int total = 0, bad = 0;
  logic [10:0] lg [0:63];
  logic [10:0] ex [0:63];
  int nlg, nex = 0, rix, wix;
  int nack_at = -1;
  logic [7:0] rvals [0:15];
  logic clr_log = 1'b0;

  always @(posedge clk) begin
    if (!rst_n || clr_log) begin
      lk_done <= 1'b0; lk_nack <= 1'b0; lk_rdata <= 8'h00;
      nlg <= 0; rix <= 0; wix <= 0;
    end else if (lk_done) begin
      lk_done <= 1'b0;
      lk_nack <= 1'b0;
    end else if (lk_req) begin
      lk_done <= 1'b1;
      if (nlg < 64) lg[nlg] <= {lk_op, lk_last, lk_wdata};
      nlg <= nlg + 1;
      if (lk_op == 2'd2) begin
        lk_rdata <= rvals[rix[3:0]];
        rix <= rix + 1;
      end
      if (lk_op == 2'd1) begin
        lk_nack <= (wix == nack_at);
        wix <= wix + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      br(3'd0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic wait_bd();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      br(3'd0, s);
      if (s[7]) break;
    end
  endtask

  task automatic new_txn();
    bw(3'd0, 8'hFF);
    nex = 0;
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  task automatic ep(input logic [1:0] op, input logic last, input logic [7:0] d);
    ex[nex] = {op, last, d};
    nex++;
  endtask

  task automatic cmp_log(input string req);
    check({req, " log length"}, nlg, nex);
    for (int i = 0; i < nex && i < nlg; i++) check({req, " log entry"}, lg[i], ex[i]);
  endtask

  task automatic stat_is(input string req, input logic [7:0] exp);
    logic [7:0] s;
    br(3'd0, s);
    check(req, s & 8'h87, exp);
  endtask

  task automatic blk_write(input int n, input bit poke);
    logic [7:0] c;
    new_txn();
    bw(3'd4, 8'h20); bw(3'd3, 8'h11); bw(3'd5, 8'(n)); bw(3'd7, 8'hB0);
    bw(3'd2, 8'h54);
    ep(0, 0, 0); ep(1, 0, 8'h20); ep(1, 0, 8'h11); ep(1, 0, 8'(n));
    for (int k = 0; k < n; k++) begin
      ep(1, 0, 8'(8'hB0 + k));
      wait_bd();
      if (poke && k == 0) begin
        bw(3'd2, 8'h48);
        br(3'd2, c);
        check("R3 control ignored while busy", c, 8'h14);
      end
      if (k == 0) stat_is("R9 no completion while waiting", 8'h81);
      if (k + 1 < n) bw(3'd7, 8'(8'hB0 + k + 1));
      bw(3'd0, 8'h80);
    end
    ep(3, 0, 0);
    wait_idle();
    cmp_log("R7 block write");
    stat_is("R7 block write status", 8'h02);
  endtask

  task automatic blk_read(input int n);
    logic [7:0] d;
    new_txn();
    rvals[0] = 8'(n);
    for (int k = 1; k < 16; k++) rvals[k] = 8'(8'hC0 + k);
    bw(3'd4, 8'h41); bw(3'd3, 8'h22); bw(3'd2, 8'h54);
    ep(0, 0, 0); ep(1, 0, 8'h40); ep(1, 0, 8'h22); ep(0, 0, 0); ep(1, 0, 8'h41);
    ep(2, 0, 0);
    wait_bd();
    br(3'd5, d);
    check("R8 count in data0", d, 8'(n));
    bw(3'd0, 8'h80);
    for (int k = 1; k <= n; k++) begin
      ep(2, k == n, 0);
      wait_bd();
      br(3'd7, d);
      check("R8 block byte", d, 8'(8'hC0 + k));
      bw(3'd0, 8'h80);
    end
    ep(3, 0, 0);
    wait_idle();
    cmp_log("R8 block read");
    stat_is("R8 block read status", 8'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values and readback
    br(3'd0, d); check("R1 status after reset", d, 8'h00);
    br(3'd2, d); check("R1 control after reset", d, 8'h00);
    bw(3'd5, 8'h9C); br(3'd5, d); check("R1 data0 readback", d, 8'h9C);
    bw(3'd6, 8'h3E); br(3'd6, d); check("R1 data1 readback", d, 8'h3E);
    // R2 semaphore
    br(3'd0, d); check("R2 second read sees in-use", d, 8'h40);
    bw(3'd0, 8'h40); br(3'd0, d); check("R2 cleared by write one", d, 8'h00);
    br(3'd0, d); check("R2 set again by read", d, 8'h40);

    // R4 send byte
    new_txn();
    bw(3'd4, 8'h5A); bw(3'd3, 8'h3C); bw(3'd2, 8'h44);
    br(3'd0, d); check("R3 busy after start", d[0], 1'b1);
    ep(0, 0, 0); ep(1, 0, 8'h5A); ep(1, 0, 8'h3C); ep(3, 0, 0);
    wait_idle(); cmp_log("R4 send byte"); stat_is("R9 complete after send", 8'h02);
    check("R12 irq off when disabled", irq, 1'b0);

    // R4 receive byte
    new_txn(); rvals[0] = 8'hA7;
    bw(3'd4, 8'h5B); bw(3'd2, 8'h44);
    ep(0, 0, 0); ep(1, 0, 8'h5B); ep(2, 1, 0); ep(3, 0, 0);
    wait_idle(); cmp_log("R4 receive byte");
    br(3'd5, d); check("R4 received in data0", d, 8'hA7);

    // R5 byte data write with irq enabled
    new_txn();
    bw(3'd4, 8'h30); bw(3'd3, 8'h07); bw(3'd5, 8'h66); bw(3'd2, 8'h49);
    ep(0, 0, 0); ep(1, 0, 8'h30); ep(1, 0, 8'h07); ep(1, 0, 8'h66); ep(3, 0, 0);
    wait_idle(); cmp_log("R5 byte data write");
    @(negedge clk); check("R12 irq on completion", irq, 1'b1);
    bw(3'd0, 8'h02); @(negedge clk); check("R12 irq drops after clear", irq, 1'b0);

    // R5 byte data read
    new_txn(); rvals[0] = 8'h5D;
    bw(3'd4, 8'h33); bw(3'd3, 8'h08); bw(3'd2, 8'h48);
    ep(0, 0, 0); ep(1, 0, 8'h32); ep(1, 0, 8'h08); ep(0, 0, 0); ep(1, 0, 8'h33);
    ep(2, 1, 0); ep(3, 0, 0);
    wait_idle(); cmp_log("R5 byte data read");
    br(3'd5, d); check("R5 read into data0", d, 8'h5D);

    // R6 word write / read
    new_txn();
    bw(3'd4, 8'h50); bw(3'd3, 8'h0A); bw(3'd5, 8'h12); bw(3'd6, 8'h34); bw(3'd2, 8'h4C);
    ep(0, 0, 0); ep(1, 0, 8'h50); ep(1, 0, 8'h0A); ep(1, 0, 8'h34); ep(1, 0, 8'h12); ep(3, 0, 0);
    wait_idle(); cmp_log("R6 word write low first");
    new_txn(); rvals[0] = 8'hA0; rvals[1] = 8'hA1;
    bw(3'd4, 8'h51); bw(3'd3, 8'h0B); bw(3'd2, 8'h4C);
    ep(0, 0, 0); ep(1, 0, 8'h50); ep(1, 0, 8'h0B); ep(0, 0, 0); ep(1, 0, 8'h51);
    ep(2, 0, 0); ep(2, 1, 0); ep(3, 0, 0);
    wait_idle(); cmp_log("R6 word read");
    br(3'd6, d); check("R6 low byte in data1", d, 8'hA0);
    br(3'd5, d); check("R6 high byte in data0", d, 8'hA1);

    // R7 / R8 block sweeps
    for (int n = 0; n <= 4; n++) blk_write(n, 1'b0);
    for (int n = 0; n <= 4; n++) blk_read(n);
    blk_write(2, 1'b1);

    // R3 unused protocol codes
    new_txn();
    bw(3'd2, 8'h40); bw(3'd2, 8'h50); bw(3'd2, 8'h5C);
    repeat (6) @(negedge clk);
    br(3'd0, d); check("R3 unused code leaves idle", d & 8'h87, 8'h00);
    check("R3 unused code no link activity", nlg, 0);

    // R10 no acknowledge on address
    new_txn(); nack_at = 0;
    bw(3'd4, 8'h70); bw(3'd3, 8'h01); bw(3'd2, 8'h48);
    ep(0, 0, 0); ep(1, 0, 8'h70); ep(3, 0, 0);
    wait_idle(); cmp_log("R10 address nack");
    stat_is("R10 error set, complete clear", 8'h04);
    // R10 no acknowledge on last word byte
    new_txn(); nack_at = 3;
    bw(3'd4, 8'h70); bw(3'd3, 8'h02); bw(3'd5, 8'hEE); bw(3'd6, 8'hDD); bw(3'd2, 8'h4C);
    ep(0, 0, 0); ep(1, 0, 8'h70); ep(1, 0, 8'h02); ep(1, 0, 8'hDD); ep(1, 0, 8'hEE); ep(3, 0, 0);
    wait_idle(); cmp_log("R10 data nack");
    stat_is("R10 error after data nack", 8'h04);
    nack_at = -1;

    // R11 kill during block wait
    new_txn();
    bw(3'd4, 8'h20); bw(3'd3, 8'h11); bw(3'd5, 8'd3); bw(3'd7, 8'hB0); bw(3'd2, 8'h54);
    wait_bd();
    bw(3'd2, 8'h02);
    repeat (4) @(negedge clk);
    br(3'd0, d); check("R11 kill returns idle without completion", d & 8'h07, 8'h00);
    check("R11 no stop after kill", nlg, 5);
    new_txn();
    bw(3'd4, 8'h5A); bw(3'd3, 8'h3D); bw(3'd2, 8'h44);
    ep(0, 0, 0); ep(1, 0, 8'h5A); ep(1, 0, 8'h3D); ep(3, 0, 0);
    wait_idle(); cmp_log("R11 usable after kill");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule